// File: doc/BRIEF.md
# Event Packet Timestamp Capture Queue

This block keeps the start-of-packet timestamps of timing-event messages seen on a port, one entry per message. An entry holds a nanoseconds field, a seconds field, the message sequence number, a 4-bit message kind and a flag that tells transmit from receive. Packet recognition and the time source sit upstream. They present one capture per cycle on a strobe with the fields alongside.

A host reaches the queue through a small 16-bit register window. It first enables capture: a global time-sync switch, plus separate switches for the transmit and receive directions. It polls a pending flag in the status word. To drain an entry it opens a read, which freezes the oldest entry into a snapshot. It then reads the snapshot word by word. It closes the read with an end write followed by a zero write, and that releases the entry. The queue is eight entries deep by default. A capture that finds it full is lost and leaves a sticky overflow flag.

Register offsets: 0 global enable (bit 0); 1 direction enables (bit 0 transmit, bit 8 receive); 2 read control (bit 0 open, bit 1 end); 3 status (bit 1 pending, bit 2 overflow); 4 to 7 snapshot nanoseconds low, nanoseconds high, seconds low, seconds high; 8 sequence number; 9 info word.

Top module: `evt_ts_capture_queue`

## Requirements
- R1: After reset the status word, both enable registers and every snapshot word read 0.
- R2: A capture is stored only when the global enable (offset 0 bit 0) is set and the enable for its direction is set: offset 1 bit 0 for transmit (capDir=1) or bit 8 for receive (capDir=0). Otherwise it leaves the queue unchanged.
- R3: Status bit 1 reads 1 while at least one entry is stored and drops to 0 once the last entry is released.
- R4: Writing offset 2 with bit 0 set while no read is open copies the oldest entry into the snapshot. Later captures do not alter the snapshot until that entry is released.
- R5: Offsets 4, 5, 6 and 7 return, in that order, nanoseconds[15:0], nanoseconds[31:16], seconds[15:0] and seconds[31:16] of the snapshot.
- R6: Offset 8 returns the 16-bit sequence number exactly as presented on capSeqId, with no byte swap. Offset 9 returns the message kind in bits [15:12], the direction in bit 11 (1 = transmit), and 0 in bits [10:0].
- R7: An open read releases its entry only when offset 2 is written with bit 1 set and then written with 0. A zero write with no preceding end write releases nothing. Entries leave in the order they were captured.
- R8: The queue holds DEPTH (default 8) entries. A capture that arrives while it is full, with no release in the same cycle, is dropped and sets status bit 2. Bit 2 stays set until the host writes offset 3 with bit 2 set.
- R9: A release and a capture in the same cycle on a full queue both take effect, with no overflow.
- R10: Opening a read on an empty queue gives a snapshot of all zeros. The end handshake that follows changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| capValid | input | 1 | Capture strobe, one entry per cycle |
| capDir | input | 1 | 1 = transmitted packet, 0 = received |
| capSeqId | input | 16 | Message sequence number |
| capMsgType | input | 4 | Message kind |
| capNs | input | 32 | Start-of-packet time, nanoseconds |
| capSec | input | 32 | Start-of-packet time, seconds |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for reads and writes |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr, combinational |

## Verification
A wrong occupancy count shows up in the pending bit. It reads 1 after the last release or 0 with entries left, and the host sees this at the very next status read. A pointer slip shows up as a drained entry carrying the wrong sequence number or time. This is seen when the first entry after the slip is opened, so every drain compares all six words. A snapshot that is not held, or a release taken from a bare zero write, changes the words read inside the same open read. For that reason the bench captures in the middle of a read and also writes zero in the middle of a read.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  parameter int NS_W   = 32;
  parameter int SEC_W  = 32;
  parameter int SEQ_W  = 16;
  parameter int TYPE_W = 4;
  parameter int REG_W  = 16;
  parameter int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_GLOBAL = 4'd0;
  localparam logic [ADDR_W-1:0] A_SLICE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_RDCTL  = 4'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd3;
  localparam logic [ADDR_W-1:0] A_NS_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_NS_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_SEC_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_SEC_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_SEQ    = 4'd8;
  localparam logic [ADDR_W-1:0] A_INFO   = 4'd9;

  typedef struct packed {
    logic              dir;
    logic [TYPE_W-1:0] msgType;
    logic [SEQ_W-1:0]  seqId;
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
  } tsEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic freeze;
    logic clrOvf;
  } qStrobe_t;

  typedef enum logic [1:0] {RD_IDLE, RD_OPEN, RD_CLOSING} rdState_e;
endpackage

// File: rtl/tsq_datapath.sv
module tsq_datapath
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  tsEntry_t         capEntry,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output tsEntry_t         snap,
  output logic             snapVld
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  tsEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             full, empty, doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPop  = strobe.pop && !empty;
  assign doPush = strobe.push && (!full || doPop);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (doPush && wrPtr == PTR_W'(g)) mem[g] <= capEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovf <= 1'b0;
    end else if (strobe.push && full && !doPop) begin
      ovf <= 1'b1;
    end else if (strobe.clrOvf) begin
      ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snap    <= '0;
      snapVld <= 1'b0;
    end else if (strobe.freeze) begin
      snap    <= empty ? '0 : mem[rdPtr];
      snapVld <= !empty;
    end else if (doPop) begin
      snap    <= '0;
      snapVld <= 1'b0;
    end
  end
endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capValid,
  input  logic              capDir,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovf,
  input  tsEntry_t          snap,
  input  logic              snapVld,
  output qStrobe_t          strobe,
  output logic              syncEn,
  output logic [REG_W-1:0]  regRdData
);
  logic     txEn, rxEn, wrCtl, wrZero;
  rdState_e rdState;

  assign wrCtl  = regWrEn && (regAddr == A_RDCTL);
  assign wrZero = (regWrData == '0);

  always_comb begin
    strobe.push   = capValid && syncEn && (capDir ? txEn : rxEn);
    strobe.freeze = wrCtl && regWrData[0] && (rdState == RD_IDLE);
    strobe.pop    = wrCtl && wrZero && (rdState == RD_CLOSING) && snapVld;
    strobe.clrOvf = regWrEn && (regAddr == A_STATUS) && regWrData[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncEn <= 1'b0;
      txEn   <= 1'b0;
      rxEn   <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == A_GLOBAL) syncEn <= regWrData[0];
      if (regAddr == A_SLICE) begin
        txEn <= regWrData[0];
        rxEn <= regWrData[8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdState <= RD_IDLE;
    end else if (wrCtl) begin
      unique case (rdState)
        RD_IDLE:    if (regWrData[0]) rdState <= RD_OPEN;
        RD_OPEN:    if (regWrData[1]) rdState <= RD_CLOSING;
        RD_CLOSING: if (wrZero)       rdState <= RD_IDLE;
        default:    rdState <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      A_GLOBAL: regRdData[0] = syncEn;
      A_SLICE: begin
        regRdData[0] = txEn;
        regRdData[8] = rxEn;
      end
      A_STATUS: begin
        regRdData[1] = (count != '0);
        regRdData[2] = ovf;
      end
      A_NS_LO:  regRdData = snap.ns[15:0];
      A_NS_HI:  regRdData = snap.ns[31:16];
      A_SEC_LO: regRdData = snap.sec[15:0];
      A_SEC_HI: regRdData = snap.sec[31:16];
      A_SEQ:    regRdData = snap.seqId;
      A_INFO: begin
        regRdData[15:12] = snap.msgType;
        regRdData[11]    = snap.dir;
      end
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/evt_ts_capture_queue.sv
module evt_ts_capture_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capValid,
  input  logic              capDir,
  input  logic [SEQ_W-1:0]  capSeqId,
  input  logic [TYPE_W-1:0] capMsgType,
  input  logic [NS_W-1:0]   capNs,
  input  logic [SEC_W-1:0]  capSec,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData
);
  qStrobe_t         strobe;
  tsEntry_t         capEntry, snap;
  logic [CNT_W-1:0] count;
  logic             ovf, snapVld, syncEn;

  assign capEntry = '{dir: capDir, msgType: capMsgType, seqId: capSeqId,
                      sec: capSec, ns: capNs};

  tsq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capDir(capDir),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .count(count), .ovf(ovf), .snap(snap), .snapVld(snapVld),
    .strobe(strobe), .syncEn(syncEn), .regRdData(regRdData)
  );

  tsq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capEntry(capEntry),
    .count(count), .ovf(ovf), .snap(snap), .snapVld(snapVld)
  );
endmodule

// File: rtl/evt_ts_capture_queue_chk.sv
module evt_ts_capture_queue_chk
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             capValid,
  input logic             syncEn,
  input qStrobe_t         strobe,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input tsEntry_t         snap,
  input logic             snapVld
);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  p_push_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop && count < CNT_W'(DEPTH))
      |=> count == $past(count) + 1'b1);

  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push && count != '0)
      |=> count == $past(count) - 1'b1);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strobe.clrOvf) |=> ovf);

  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (snapVld && !strobe.freeze && !strobe.pop) |=> $stable(snap));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !syncEn && !strobe.pop) |=> count == $past(count));
endmodule

bind evt_ts_capture_queue evt_ts_capture_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .capValid(capValid), .syncEn(syncEn),
  .strobe(strobe), .count(count), .ovf(ovf), .snap(snap), .snapVld(snapVld)
);

// File: tb/evt_ts_capture_queue_tb.sv
module evt_ts_capture_queue_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capValid = 1'b0, capDir = 1'b0;
  logic [15:0] capSeqId = '0;
  logic [3:0]  capMsgType = '0;
  logic [31:0] capNs = '0, capSec = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0, regRdData;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_ts_capture_queue u_dut (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capDir(capDir),
    .capSeqId(capSeqId), .capMsgType(capMsgType), .capNs(capNs),
    .capSec(capSec), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(string tag, logic [3:0] a, logic [15:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic capture(logic dir, logic [15:0] seq, logic [3:0] typ,
                         logic [31:0] ns, logic [31:0] sec);
    @(negedge clk);
    capValid = 1'b1; capDir = dir; capSeqId = seq; capMsgType = typ;
    capNs = ns; capSec = sec;
    @(negedge clk);
    capValid = 1'b0;
  endtask

  task automatic checkSnap(string tag, logic dir, logic [15:0] seq,
                           logic [3:0] typ, logic [31:0] ns, logic [31:0] sec);
    regCheck({tag, " R5 nsLo"}, 4'd4, ns[15:0]);
    regCheck({tag, " R5 nsHi"}, 4'd5, ns[31:16]);
    regCheck({tag, " R5 secLo"}, 4'd6, sec[15:0]);
    regCheck({tag, " R5 secHi"}, 4'd7, sec[31:16]);
    regCheck({tag, " R6 seq"}, 4'd8, seq);
    regCheck({tag, " R6 info"}, 4'd9, {typ, dir, 11'd0});
  endtask

  task automatic drain(string tag, logic dir, logic [15:0] seq,
                       logic [3:0] typ, logic [31:0] ns, logic [31:0] sec);
    regWrite(4'd2, 16'h0001);
    checkSnap(tag, dir, seq, typ, ns, sec);
    regWrite(4'd2, 16'h0002);
    regWrite(4'd2, 16'h0000);
  endtask

  task automatic t_reset;
    regCheck("R1 status", 4'd3, 16'h0000);
    regCheck("R1 global", 4'd0, 16'h0000);
    regCheck("R1 slice", 4'd1, 16'h0000);
    checkSnap("R1 snap", 1'b0, 16'h0, 4'h0, 32'h0, 32'h0);
  endtask

  task automatic t_gating;
    capture(1'b1, 16'h0011, 4'h0, 32'h1, 32'h2);
    regCheck("R2 all off", 4'd3, 16'h0000);
    regWrite(4'd0, 16'h0001);
    capture(1'b1, 16'h0012, 4'h0, 32'h1, 32'h2);
    regCheck("R2 slice off", 4'd3, 16'h0000);
    regWrite(4'd1, 16'h0001);
    capture(1'b0, 16'h0013, 4'h0, 32'h1, 32'h2);
    regCheck("R2 rx blocked", 4'd3, 16'h0000);
    capture(1'b1, 16'h0014, 4'h2, 32'h5, 32'h6);
    regCheck("R2 tx stored R3", 4'd3, 16'h0002);
    drain("R2 drain", 1'b1, 16'h0014, 4'h2, 32'h5, 32'h6);
    regCheck("R3 cleared", 4'd3, 16'h0000);
    regWrite(4'd1, 16'h0100);
    capture(1'b1, 16'h0015, 4'h0, 32'h1, 32'h2);
    regCheck("R2 tx blocked", 4'd3, 16'h0000);
    capture(1'b0, 16'h0016, 4'hB, 32'h7, 32'h8);
    regCheck("R2 rx stored", 4'd3, 16'h0002);
    drain("R2 rx drain", 1'b0, 16'h0016, 4'hB, 32'h7, 32'h8);
    regWrite(4'd1, 16'h0101);
  endtask

  task automatic t_fields;
    capture(1'b1, 16'h1234, 4'h3, 32'h89AB_CDEF, 32'h0123_4567);
    capture(1'b0, 16'hA55A, 4'hF, 32'hFFFF_0001, 32'h8000_7FFE);
    drain("R6 tx fields", 1'b1, 16'h1234, 4'h3, 32'h89AB_CDEF, 32'h0123_4567);
    drain("R6 rx fields", 1'b0, 16'hA55A, 4'hF, 32'hFFFF_0001, 32'h8000_7FFE);
    regCheck("R3 empty", 4'd3, 16'h0000);
  endtask

  task automatic t_freeze_handshake;
    capture(1'b1, 16'h0A01, 4'h1, 32'h10, 32'h20);
    regWrite(4'd2, 16'h0001);
    capture(1'b0, 16'h0A02, 4'h2, 32'h30, 32'h40);
    checkSnap("R4 frozen", 1'b1, 16'h0A01, 4'h1, 32'h10, 32'h20);
    regWrite(4'd2, 16'h0000);
    checkSnap("R7 bare zero", 1'b1, 16'h0A01, 4'h1, 32'h10, 32'h20);
    regWrite(4'd2, 16'h0002);
    regWrite(4'd2, 16'h0000);
    drain("R7 second", 1'b0, 16'h0A02, 4'h2, 32'h30, 32'h40);
    regCheck("R3 drained", 4'd3, 16'h0000);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 9; i++)
      capture(1'b1, 16'h0200 + 16'(i), 4'h4, 32'(i), 32'(i + 100));
    regCheck("R8 ovf set", 4'd3, 16'h0006);
    for (int i = 0; i < 8; i++)
      drain("R8 order R7", 1'b1, 16'h0200 + 16'(i), 4'h4, 32'(i), 32'(i + 100));
    regCheck("R8 sticky", 4'd3, 16'h0004);
    regWrite(4'd3, 16'h0004);
    regCheck("R8 cleared", 4'd3, 16'h0000);
  endtask

  task automatic t_concurrent;
    for (int i = 0; i < 8; i++)
      capture(1'b0, 16'h0300 + 16'(i), 4'h5, 32'(i), 32'h9);
    regWrite(4'd2, 16'h0001);
    regWrite(4'd2, 16'h0002);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd2; regWrData = 16'h0000;
    capValid = 1'b1; capDir = 1'b0; capSeqId = 16'h03FF; capMsgType = 4'h6;
    capNs = 32'hDEAD_BEEF; capSec = 32'h9;
    @(negedge clk);
    regWrEn = 1'b0; capValid = 1'b0;
    regCheck("R9 no ovf", 4'd3, 16'h0002);
    for (int i = 1; i < 8; i++)
      drain("R9 order", 1'b0, 16'h0300 + 16'(i), 4'h5, 32'(i), 32'h9);
    drain("R9 last", 1'b0, 16'h03FF, 4'h6, 32'hDEAD_BEEF, 32'h9);
    regCheck("R9 empty", 4'd3, 16'h0000);
  endtask

  task automatic t_empty_read;
    regWrite(4'd2, 16'h0001);
    checkSnap("R10 empty snap", 1'b0, 16'h0, 4'h0, 32'h0, 32'h0);
    regWrite(4'd2, 16'h0002);
    regWrite(4'd2, 16'h0000);
    regCheck("R10 status", 4'd3, 16'h0000);
    capture(1'b1, 16'h0777, 4'h7, 32'h77, 32'h78);
    drain("R10 after", 1'b1, 16'h0777, 4'h7, 32'h77, 32'h78);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_gating();
    t_fields();
    t_freeze_handshake();
    t_overflow();
    t_concurrent();
    t_empty_read();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule